// File: doc/BRIEF.md
# Transmit Burst Framing Controller

This block sits ahead of a transmit character encoder and picks, once per word cycle, what the encoder is given. While the idle request is low, input words pass through as data. When the idle request goes high, the block closes the burst and then sends idle sets. It closes with a single abort-class end-of-frame set, which restores correct running disparity. If CRC generation is enabled, a 32-bit CRC word comes first. Every output word carries a one-hot type tag. The exact character patterns of the ordered sets are left to the encoder.

A running CRC is kept over the data words of each burst. With generation enabled, the inverted CRC goes out as the first closing word. With generation disabled, the block expects the caller to have placed the CRC as the last data word of the burst, and it raises a one-cycle error pulse if that word does not match. The block also checks odd parity on each input byte of data words. It raises a protocol flag if, with CRC enabled, the idle request falls after only one high cycle.

Top module: `tx_burst_framer`

## Requirements
- R1: With the idle request low, the word on the data input appears on the output one clock later, tagged as data.
- R2: With CRC generation off, the first idle-request cycle after a data word yields one abort set. Every later cycle of that idle run yields an idle set.
- R3: With CRC generation on, the first idle-request cycle after a data word yields the CRC word and the second yields the abort set. Idle sets follow.
- R4: In cycles with the idle request high, the data and parity inputs have no effect. The output word is zero for abort and idle sets, and no parity error is raised.
- R5: The CRC is computed MSB first with polynomial 0x04C11DB7. It is preset to all ones at the first data word after any idle cycle or reset. The transmitted CRC word is the bitwise inverse of the remainder.
- R6: With generation off, the crc_err output pulses high for one cycle, in the same cycle as the abort set, when the last data word of the burst differs from the inverted CRC of the words before it.
- R7: An idle run that follows reset, rather than a data word, yields only idle sets, whatever the CRC enable.
- R8: With generation on, a data word that arrives after exactly one idle-request cycle gives a one-cycle proto_err pulse, aligned with that data word's output.
- R9: For each lane k, the data bits [8k+7:8k] and parity bit k must together hold an odd number of ones. Any failing lane in a data cycle gives a one-cycle par_err pulse, aligned with that word's output.
- R10: The tag encoding is bit0 data, bit1 CRC, bit2 abort, bit3 idle, and exactly one bit is set. During reset the tag is idle, the word is zero and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 32 | Word to send |
| par_in | input | 4 | Odd parity bit per input byte |
| idle_req | input | 1 | High to close the burst and send idle |
| crc_gen_en | input | 1 | High to append the CRC; low to check it |
| out_word | output | 32 | Registered word for the encoder |
| out_kind | output | 4 | One-hot tag: data, CRC, abort, idle |
| crc_err | output | 1 | CRC mismatch pulse (generation off) |
| par_err | output | 1 | Input byte parity mismatch pulse |
| proto_err | output | 1 | Idle gap too short with CRC on |

## Verification
The hardest case to reach is the CRC check passing with generation off. For that, the final data word of a burst must equal the inverted CRC of all the earlier words in that burst. The bench tracks the CRC arithmetically while it drives each burst and places the matching word at the end of even-length bursts. It places an arbitrary word at the end of odd-length bursts. Bursts of one to four words are swept with both enable settings, so both outcomes are seen, including the one-word burst, where the word must equal the inverted preset.

// File: rtl/tbf_pkg.sv
`timescale 1ns/1ps
package tbf_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [3:0] {
    KIND_DATA  = 4'b0001,
    KIND_CRC   = 4'b0010,
    KIND_ABORT = 4'b0100,
    KIND_IDLE  = 4'b1000
  } kind_t;

  // One word through the CRC, most significant bit first
  function automatic logic [WORD_W-1:0] crc_word(input logic [WORD_W-1:0] seed,
                                                 input logic [WORD_W-1:0] d,
                                                 input logic [WORD_W-1:0] poly);
    logic [WORD_W-1:0] c;
    c = seed;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (c[WORD_W-1] ^ d[i]) c = {c[WORD_W-2:0], 1'b0} ^ poly;
      else                    c = {c[WORD_W-2:0], 1'b0};
    end
    return c;
  endfunction

  // High when a byte and its parity bit hold an even count of ones
  function automatic logic lane_bad(input logic [7:0] b, input logic p);
    return ~(^{b, p});
  endfunction
endpackage

// File: rtl/tbf_gap_ctrl.sv
`timescale 1ns/1ps
module tbf_gap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_req,
  input  logic crc_gen_en,
  output logic data_slot,
  output logic burst_start,
  output logic first_idle,
  output logic crc_slot,
  output logic abort_slot,
  output logic short_gap
);
  // run: 0 = last cycle was data, 1 = one idle cycle, 2 = two or more
  logic [1:0] run_q;
  logic       crc_sent_q;

  assign data_slot   = !idle_req;
  assign burst_start = data_slot && (run_q != 2'd0);
  assign first_idle  = idle_req && (run_q == 2'd0);
  assign crc_slot    = first_idle && crc_gen_en;
  assign abort_slot  = (first_idle && !crc_gen_en) ||
                       (idle_req && (run_q == 2'd1) && crc_sent_q);
  assign short_gap   = data_slot && (run_q == 2'd1) && crc_sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 2'd2;
      crc_sent_q <= 1'b0;
    end else if (idle_req) begin
      if (run_q != 2'd2) run_q <= run_q + 2'd1;
      if (first_idle)    crc_sent_q <= crc_gen_en;
    end else begin
      run_q <= 2'd0;
    end
  end
endmodule

// File: rtl/tbf_crc_unit.sv
`timescale 1ns/1ps
module tbf_crc_unit #(
  parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       data_slot,
  input  logic                       burst_start,
  input  logic [tbf_pkg::WORD_W-1:0] data_in,
  output logic [tbf_pkg::WORD_W-1:0] crc_tx,
  output logic                       check_fail
);
  localparam int W = tbf_pkg::WORD_W;
  localparam logic [W-1:0] PRESET = '1;

  logic [W-1:0] run_q, before_q, last_q, base;

  assign base       = burst_start ? PRESET : run_q;
  assign crc_tx     = ~run_q;
  assign check_fail = (last_q != ~before_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= PRESET;
      before_q <= PRESET;
      last_q   <= '0;
    end else if (data_slot) begin
      run_q    <= tbf_pkg::crc_word(base, data_in, POLY);
      before_q <= base;
      last_q   <= data_in;
    end
  end
endmodule

// File: rtl/tbf_par_check.sv
`timescale 1ns/1ps
module tbf_par_check (
  input  logic [tbf_pkg::WORD_W-1:0] data_in,
  input  logic [tbf_pkg::LANES-1:0]  par_in,
  output logic                       any_bad
);
  logic [tbf_pkg::LANES-1:0] lane_bad;

  for (genvar k = 0; k < tbf_pkg::LANES; k++) begin : g_lane
    assign lane_bad[k] = tbf_pkg::lane_bad(data_in[8*k +: 8], par_in[k]);
  end

  assign any_bad = |lane_bad;
endmodule

// File: rtl/tx_burst_framer.sv
`timescale 1ns/1ps
module tx_burst_framer #(
  parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] data_in,
  input  logic [3:0]  par_in,
  input  logic        idle_req,
  input  logic        crc_gen_en,
  output logic [31:0] out_word,
  output logic [3:0]  out_kind,
  output logic        crc_err,
  output logic        par_err,
  output logic        proto_err
);
  import tbf_pkg::*;

  logic data_slot, burst_start, first_idle, crc_slot, abort_slot, short_gap;
  logic check_fail, any_bad;
  logic [WORD_W-1:0] crc_tx;

  tbf_gap_ctrl u_gap (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .crc_gen_en(crc_gen_en),
    .data_slot(data_slot), .burst_start(burst_start), .first_idle(first_idle),
    .crc_slot(crc_slot), .abort_slot(abort_slot), .short_gap(short_gap)
  );

  tbf_crc_unit #(.POLY(POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .data_slot(data_slot), .burst_start(burst_start),
    .data_in(data_in), .crc_tx(crc_tx), .check_fail(check_fail)
  );

  tbf_par_check u_par (.data_in(data_in), .par_in(par_in), .any_bad(any_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_kind  <= KIND_IDLE;
      crc_err   <= 1'b0;
      par_err   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (data_slot) begin
        out_word <= data_in;
        out_kind <= KIND_DATA;
      end else if (crc_slot) begin
        out_word <= crc_tx;
        out_kind <= KIND_CRC;
      end else if (abort_slot) begin
        out_word <= '0;
        out_kind <= KIND_ABORT;
      end else begin
        out_word <= '0;
        out_kind <= KIND_IDLE;
      end
      crc_err   <= first_idle && !crc_gen_en && check_fail;
      par_err   <= data_slot && any_bad;
      proto_err <= short_gap;
    end
  end
endmodule

// File: rtl/tbf_checker.sv
`timescale 1ns/1ps
module tbf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] data_in,
  input logic [3:0]  par_in,
  input logic        idle_req,
  input logic        crc_gen_en,
  input logic [31:0] out_word,
  input logic [3:0]  out_kind,
  input logic        crc_err,
  input logic        par_err,
  input logic        proto_err,
  input logic        first_idle,
  input logic        short_gap,
  input logic [31:0] crc_tx
);
  logic in_par_bad;
  always_comb begin
    in_par_bad = 1'b0;
    for (int k = 0; k < 4; k++)
      if (^{data_in[8*k +: 8], par_in[k]} == 1'b0) in_par_bad = 1'b1;
  end

  assert_kind_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_kind) == 1);

  assert_data_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> (out_kind == 4'b0001) && (out_word == $past(data_in)));

  assert_abort_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (first_idle && !crc_gen_en) |=> (out_kind == 4'b0100));

  assert_crc_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_idle && crc_gen_en) |=> (out_kind == 4'b0010) && (out_word == $past(crc_tx)));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |=> (out_kind != 4'b0001) && !par_err);

  assert_crc_err_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (out_kind == 4'b0100) && !$past(crc_gen_en));

  assert_short_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    short_gap |=> proto_err);

  assert_parity_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_req && in_par_bad) |=> par_err);
endmodule

bind tx_burst_framer tbf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .par_in(par_in),
  .idle_req(idle_req), .crc_gen_en(crc_gen_en), .out_word(out_word),
  .out_kind(out_kind), .crc_err(crc_err), .par_err(par_err),
  .proto_err(proto_err), .first_idle(first_idle), .short_gap(short_gap),
  .crc_tx(crc_tx)
);

// File: tb/tx_burst_framer_test.sv
`timescale 1ns/1ps
module tx_burst_framer_test;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] data_in = '0;
  logic [3:0]  par_in = '0;
  logic idle_req = 1'b1, crc_gen_en = 1'b0;
  logic [31:0] out_word;
  logic [3:0]  out_kind;
  logic crc_err, par_err, proto_err;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  int          m_run = 2;
  bit          m_sent = 1'b0;
  logic [31:0] m_crc = '1, m_before = '1, m_last = '0;
  logic [31:0] seed = 32'h1357_9BDF;

  tx_burst_framer uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .par_in(par_in),
    .idle_req(idle_req), .crc_gen_en(crc_gen_en), .out_word(out_word),
    .out_kind(out_kind), .crc_err(crc_err), .par_err(par_err), .proto_err(proto_err)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c ^ d;
    for (int i = 0; i < 32; i++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  function automatic logic [3:0] odd_par(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ~(^d[8*k +: 8]);
    return p;
  endfunction

  function automatic logic [31:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  task automatic compare(input string tag, input logic [31:0] ew, input logic [3:0] ek,
                         input logic ec, input logic ep, input logic eq);
    checks++;
    if (out_word !== ew || out_kind !== ek || crc_err !== ec || par_err !== ep || proto_err !== eq) begin
      fails++;
      $display("FAIL %s: got word=%h kind=%b crc=%b par=%b proto=%b, expected word=%h kind=%b crc=%b par=%b proto=%b",
               tag, out_word, out_kind, crc_err, par_err, proto_err, ew, ek, ec, ep, eq);
    end
  endtask

  // Called at a falling edge; drives one word cycle and checks the registered result
  task automatic step(input string tag, input bit req, input bit gen,
                      input logic [31:0] d, input logic [3:0] p);
    logic [31:0] ew; logic [3:0] ek; logic ec, ep, eq;
    logic [31:0] base;
    ew = '0; ek = 4'b1000; ec = 0; ep = 0; eq = 0;
    idle_req = req; crc_gen_en = gen; data_in = d; par_in = p;
    if (!req) begin
      ek = 4'b0001; ew = d;
      ep = (p != odd_par(d));
      eq = (m_run == 1) && m_sent;
      base = (m_run != 0) ? 32'hFFFF_FFFF : m_crc;
      m_before = base; m_crc = ref_crc(base, d); m_last = d; m_run = 0;
    end else begin
      if (m_run == 0) begin
        if (gen) begin ek = 4'b0010; ew = ~m_crc; end
        else begin ek = 4'b0100; ec = (m_last != ~m_before); end
        m_sent = gen;
      end else if (m_run == 1 && m_sent) begin
        ek = 4'b0100;
      end
      if (m_run < 2) m_run++;
    end
    @(negedge clk);
    compare(tag, ew, ek, ec, ep, eq);
  endtask

  task automatic data_word(input string tag, input bit gen, input logic [31:0] d);
    step(tag, 1'b0, gen, d, odd_par(d));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10 reset state", 32'h0, 4'b1000, 0, 0, 0);
    rst_n = 1'b1;

    // R7: idle straight after reset, inputs garbage with bad parity
    step("R7 idle after reset", 1, 0, 32'hDEAD_BEEF, 4'h0);
    step("R7 idle after reset", 1, 1, 32'hFFFF_FFFF, 4'hF);
    step("R7 idle after reset", 1, 1, 32'h0000_0000, 4'h0);

    // Burst length sweep for both enable settings
    for (int g = 0; g < 2; g++) begin
      for (int n = 1; n <= 4; n++) begin
        for (int i = 0; i < n; i++) begin
          logic [31:0] w;
          w = next_word();
          if (g == 0 && i == n - 1 && (n % 2 == 0))
            w = (m_run != 0) ? 32'h0 : ~m_crc;  // correct CRC placed by caller
          if (g == 0 && n == 1 && i == 0 && (seed[0]))
            w = 32'h0;                          // one-word burst equal to inverted preset
          data_word("R1 data pass", g[0], w);
        end
        step(g ? "R3 R5 crc word" : "R2 R6 abort and check", 1, g[0], 32'hA5A5_A5A5, 4'h0);
        step(g ? "R3 abort after crc" : "R2 R4 idle", 1, g[0], 32'h5A5A_5A5A, 4'hF);
        step("R4 idle ignores inputs", 1, g[0], next_word(), 4'h3);
      end
    end

    // R5: identical bursts back to back give identical CRC (preset at burst start)
    for (int r = 0; r < 2; r++) begin
      data_word("R1 R5 repeat burst", 1, 32'h0102_0304);
      data_word("R1 R5 repeat burst", 1, 32'hCAFE_F00D);
      step("R5 crc repeat", 1, 1, '0, '0);
      step("R3 abort", 1, 1, '0, '0);
    end

    // R9: one bad lane at a time, then all bad
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = next_word();
      step("R9 lane parity", 0, 0, w, odd_par(w) ^ (4'b1 << k));
    end
    step("R9 all lanes bad", 0, 0, 32'h1234_5678, ~odd_par(32'h1234_5678));
    data_word("R9 good parity", 0, 32'h8000_0001);

    // R8: gap of one cycle with CRC on
    step("R3 crc", 1, 1, '0, '0);
    data_word("R8 short gap", 1, 32'h7777_0000);
    data_word("R1 after short gap", 1, 32'h0000_7777);
    step("R3 crc", 1, 1, '0, '0);
    step("R3 abort", 1, 1, '0, '0);
    data_word("R8 legal gap", 1, 32'h1111_2222);
    // R6 explicit mismatch with generation off
    data_word("R1 data", 0, 32'h3333_4444);
    step("R6 crc mismatch", 1, 0, '0, '0);
    step("R2 idle", 1, 0, '0, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule